// File: doc/BRIEF.md
# NVRAM Range Checksum Engine

This block walks a byte range of a byte-addressed non-volatile memory, folds the bytes into a 16-bit checksum, and stores the result back into the same memory. A single start pulse supplies three values: the first address, the byte count and the address that receives the result. The engine then reads the memory through a single-port byte interface that has one cycle of read latency. When the result has been written, the engine raises a one-cycle done pulse.

Words are built big-endian: the byte at address A is the high half and the byte at A+1 is the low half. The word pointer advances by one byte per word, so each word shares a byte with the word before it. The word loop covers the count with its lowest bit cleared. An odd count adds one more update, in which the last byte is the high half and the low half is zero. Each update is a nibble fold. With p = checksum XOR word, n1 = p[3:0] and n2 = p[7:4] XOR n1, the new value is (p >> 8) XOR (n1 << 3) XOR (n1 << 8) XOR n2 XOR (n2 << 7) XOR (n2 << 12), truncated to 16 bits. A typical header check covers 0xF8 bytes from address 0 and places the result at offset 0xFC.

The controller has nine states:
- S_IDLE waits for start.
- S_ADDR_HI issues the read of the high byte.
- S_ADDR_LO captures that byte and issues the read of the low byte.
- S_FOLD updates the checksum and steps the pointer.
- S_ADDR_TAIL reads the odd last byte.
- S_FOLD_TAIL folds that byte.
- S_PUT_HI and S_PUT_LO write the two result bytes.
- S_FINISH pulses done.

Transitions:
- S_IDLE goes to S_ADDR_HI when the even count is nonzero. Otherwise it goes to S_ADDR_TAIL when the count is odd, and to S_PUT_HI otherwise.
- S_FOLD returns to S_ADDR_HI while words remain. After the last word it goes to S_ADDR_TAIL when the count is odd, and to S_PUT_HI otherwise.
- S_FINISH returns to S_IDLE.

Top module: `nvram_sum_engine`

## Requirements
- R1: After reset the engine is idle: busy, done, mem_rd_en and mem_wr_en are low and checksum reads 0xFFFF. While idle, no memory access is issued.
- R2: Every job starts its checksum at 0xFFFF. A job with a byte count of 0 writes 0xFF to both result bytes.
- R3: Word k of the loop is {mem[start+k], mem[start+k+1]}, with the lower address as the high byte. k runs from 0 to (count with bit 0 cleared) - 1, so neighbouring words overlap by one byte.
- R4: Each update follows the nibble fold given above. From 0xFFFF, two zero words give 0x0F87 and then 0xF0B8.
- R5: When the count is odd, a last update folds {mem[start+count-1], 8'h00}. From 0xFFFF, a single zero byte gives 0x0F87.
- R6: The result is written big-endian, high byte at dest and low byte at dest+1, in two consecutive cycles. No other memory address is written.
- R7: done is high for exactly one cycle, in the cycle after the low result byte is written. In the cycle after done, busy is low.
- R8: A start pulse while busy is ignored. The running job keeps its parameters and its result.
- R9: After done, the checksum output holds the value that was written until the next job starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle job request, taken only while idle |
| start_addr | input | AW | First byte address of the range |
| byte_count | input | AW | Number of bytes covered |
| dest_addr | input | AW | Address of the result's high byte |
| mem_rd_en | output | 1 | Byte read request |
| mem_rd_addr | output | AW | Byte read address |
| mem_rd_data | input | 8 | Read data, valid the cycle after the request |
| mem_wr_en | output | 1 | Byte write strobe |
| mem_wr_addr | output | AW | Byte write address |
| mem_wr_data | output | 8 | Byte write data |
| busy | output | 1 | High from job acceptance through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| checksum | output | 16 | Current or last checksum value |

## Verification
The main path is exercised with four kinds of range:
- An all-zero range whose values are known by hand, which pins the fold arithmetic itself.
- A three-byte range of distinct bytes with an even count of two, which shows whether the pointer steps one byte or two.
- An odd count, which separates correct tail handling from a dropped or mis-shifted last byte.
- A zero count, which isolates the initial value.

A full 0xF8-byte header over a patterned memory is then compared against an independent model. Sentinel bytes around the result address show that only the two result bytes are written. A second start issued mid-job shows that requests are dropped while busy.

// File: rtl/nvram_sum_pkg.sv
package nvram_sum_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int NIB_W  = BYTE_W / 2;
    localparam logic [WORD_W-1:0] SUM_SEED = 16'hFFFF;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR_HI,
        S_ADDR_LO,
        S_FOLD,
        S_ADDR_TAIL,
        S_FOLD_TAIL,
        S_PUT_HI,
        S_PUT_LO,
        S_FINISH
    } sum_state_t;

endpackage

// File: rtl/nvram_sum_fold.sv
module nvram_sum_fold
    import nvram_sum_pkg::*;
(
    input  logic [WORD_W-1:0] prev_sum,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] next_sum
);

    logic [WORD_W-1:0] mixed;
    logic [NIB_W-1:0]  lo_nib;
    logic [NIB_W-1:0]  hi_nib;
    logic [WORD_W-1:0] lo_terms;
    logic [WORD_W-1:0] hi_terms;

    always_comb begin
        mixed    = prev_sum ^ word_in;
        lo_nib   = mixed[NIB_W-1:0];
        hi_nib   = mixed[2*NIB_W-1:NIB_W] ^ lo_nib;
        lo_terms = (WORD_W'(lo_nib) << 3) ^ (WORD_W'(lo_nib) << 8);
        hi_terms = WORD_W'(hi_nib) ^ (WORD_W'(hi_nib) << 7) ^ (WORD_W'(hi_nib) << 12);
        next_sum = (mixed >> BYTE_W) ^ lo_terms ^ hi_terms;
    end

endmodule

// File: rtl/nvram_sum_ctrl.sv
module nvram_sum_ctrl
    import nvram_sum_pkg::*;
#(
    parameter int AW = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     start_addr,
    input  logic [AW-1:0]     byte_count,
    input  logic [AW-1:0]     dest_addr,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic [WORD_W-1:0] fold_result,
    output logic [WORD_W-1:0] fold_word,
    output logic [WORD_W-1:0] sum_q,
    output logic              rd_en,
    output logic [AW-1:0]     rd_addr,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              busy,
    output logic              done
);

    localparam logic [AW-1:0] ONE = AW'(1);

    sum_state_t        state_q;
    sum_state_t        state_nx;
    logic [AW-1:0]     ptr_q;
    logic [AW-1:0]     dst_q;
    logic [AW-1:0]     words_left_q;
    logic              odd_q;
    logic [BYTE_W-1:0] hi_byte_q;
    logic [AW-1:0]     even_count;

    assign even_count = {byte_count[AW-1:1], 1'b0};

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    if (even_count != '0)    state_nx = S_ADDR_HI;
                    else if (byte_count[0])  state_nx = S_ADDR_TAIL;
                    else                     state_nx = S_PUT_HI;
                end
            end
            S_ADDR_HI:   state_nx = S_ADDR_LO;
            S_ADDR_LO:   state_nx = S_FOLD;
            S_FOLD: begin
                if (words_left_q != ONE) state_nx = S_ADDR_HI;
                else if (odd_q)          state_nx = S_ADDR_TAIL;
                else                     state_nx = S_PUT_HI;
            end
            S_ADDR_TAIL: state_nx = S_FOLD_TAIL;
            S_FOLD_TAIL: state_nx = S_PUT_HI;
            S_PUT_HI:    state_nx = S_PUT_LO;
            S_PUT_LO:    state_nx = S_FINISH;
            S_FINISH:    state_nx = S_IDLE;
            default:     state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q        <= '0;
            dst_q        <= '0;
            words_left_q <= '0;
            odd_q        <= 1'b0;
            hi_byte_q    <= '0;
            sum_q        <= SUM_SEED;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        ptr_q        <= start_addr;
                        dst_q        <= dest_addr;
                        words_left_q <= even_count;
                        odd_q        <= byte_count[0];
                        sum_q        <= SUM_SEED;
                    end
                end
                S_ADDR_LO: hi_byte_q <= rd_data;
                S_FOLD: begin
                    sum_q        <= fold_result;
                    ptr_q        <= ptr_q + ONE;
                    words_left_q <= words_left_q - ONE;
                end
                S_FOLD_TAIL: sum_q <= fold_result;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        rd_en     = 1'b0;
        rd_addr   = ptr_q;
        wr_en     = 1'b0;
        wr_addr   = dst_q;
        wr_data   = sum_q[WORD_W-1:BYTE_W];
        busy      = (state_q != S_IDLE);
        done      = 1'b0;
        fold_word = {hi_byte_q, rd_data};
        unique case (state_q)
            S_ADDR_HI:   rd_en = 1'b1;
            S_ADDR_LO: begin
                rd_en   = 1'b1;
                rd_addr = ptr_q + ONE;
            end
            S_ADDR_TAIL: rd_en = 1'b1;
            S_FOLD_TAIL: fold_word = {rd_data, {BYTE_W{1'b0}}};
            S_PUT_HI:    wr_en = 1'b1;
            S_PUT_LO: begin
                wr_en   = 1'b1;
                wr_addr = dst_q + ONE;
                wr_data = sum_q[BYTE_W-1:0];
            end
            S_FINISH:    done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/nvram_sum_engine.sv
module nvram_sum_engine
    import nvram_sum_pkg::*;
#(
    parameter int AW = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     start_addr,
    input  logic [AW-1:0]     byte_count,
    input  logic [AW-1:0]     dest_addr,
    output logic              mem_rd_en,
    output logic [AW-1:0]     mem_rd_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              mem_wr_en,
    output logic [AW-1:0]     mem_wr_addr,
    output logic [7:0]        mem_wr_data,
    output logic              busy,
    output logic              done,
    output logic [15:0]       checksum
);

    logic [WORD_W-1:0] fold_word;
    logic [WORD_W-1:0] fold_result;
    logic [WORD_W-1:0] sum_q;

    nvram_sum_ctrl #(.AW(AW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_addr  (start_addr),
        .byte_count  (byte_count),
        .dest_addr   (dest_addr),
        .rd_data     (mem_rd_data),
        .fold_result (fold_result),
        .fold_word   (fold_word),
        .sum_q       (sum_q),
        .rd_en       (mem_rd_en),
        .rd_addr     (mem_rd_addr),
        .wr_en       (mem_wr_en),
        .wr_addr     (mem_wr_addr),
        .wr_data     (mem_wr_data),
        .busy        (busy),
        .done        (done)
    );

    nvram_sum_fold u_fold (
        .prev_sum (sum_q),
        .word_in  (fold_word),
        .next_sum (fold_result)
    );

    assign checksum = sum_q;

endmodule

// File: rtl/nvram_sum_engine_chk.sv
module nvram_sum_engine_chk #(
    parameter int AW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          mem_rd_en,
    input logic          mem_wr_en,
    input logic [AW-1:0] mem_wr_addr,
    input logic          busy,
    input logic          done
);

    // R1: no memory traffic while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd_en && !mem_wr_en));

    // R6: the single port never reads and writes at once
    a_r6_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    // R6: the low result byte follows at the next address
    a_r6_write_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_en) |=> (mem_wr_en && (mem_wr_addr == $past(mem_wr_addr) + AW'(1))));

    // R7: done is a single-cycle pulse
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done comes right after a write and is followed by idle
    a_r7_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_wr_en));

    a_r7_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R8: a start while working does not end the job
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);

endmodule

bind nvram_sum_engine nvram_sum_engine_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .mem_rd_en   (mem_rd_en),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_addr (mem_wr_addr),
    .busy        (busy),
    .done        (done)
);

// File: tb/nvram_sum_engine_test.sv
`timescale 1ns/1ps
module nvram_sum_engine_test;

    localparam int AW    = 9;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [AW-1:0] byte_count = '0;
    logic [AW-1:0] dest_addr = '0;
    logic          mem_rd_en;
    logic [AW-1:0] mem_rd_addr;
    logic [7:0]    mem_rd_data;
    logic          mem_wr_en;
    logic [AW-1:0] mem_wr_addr;
    logic [7:0]    mem_wr_data;
    logic          busy;
    logic          done;
    logic [15:0]   checksum;

    logic [7:0] mem [DEPTH];

    int tests_run = 0;
    int tests_failed = 0;

    always #4 clk = ~clk;

    nvram_sum_engine #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .start_addr(start_addr), .byte_count(byte_count), .dest_addr(dest_addr),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .busy(busy), .done(done), .checksum(checksum)
    );

    // behavioural byte memory, one cycle read latency
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
        if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_fold(input logic [15:0] s, input logic [15:0] w);
        logic [15:0] p, r;
        logic [3:0] a, b;
        p = s ^ w;
        a = p[3:0];
        b = p[7:4] ^ a;
        r = p >> 8;
        r = r ^ ({12'd0, a} << 3) ^ ({12'd0, a} << 8);
        r = r ^ {12'd0, b} ^ ({12'd0, b} << 7) ^ ({12'd0, b} << 12);
        return r;
    endfunction

    function automatic logic [15:0] ref_sum(input int base, input int cnt);
        logic [15:0] s = 16'hFFFF;
        int even = cnt & ~1;
        for (int k = 0; k < even; k++)
            s = ref_fold(s, {mem[(base + k) % DEPTH], mem[(base + k + 1) % DEPTH]});
        if (cnt & 1)
            s = ref_fold(s, {mem[(base + even) % DEPTH], 8'h00});
        return s;
    endfunction

    task automatic issue(input int base, input int cnt, input int dst);
        @(negedge clk);
        start      = 1'b1;
        start_addr = AW'(base);
        byte_count = AW'(cnt);
        dest_addr  = AW'(dst);
        @(negedge clk);
        start = 1'b0;
    endtask

    // waits for done, checks R7 pulse shape and R9 hold
    task automatic await_done(input string tag);
        int n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(done, {tag, " R7 done seen"}, 32'(done), 32'd1);
        @(negedge clk);
        chk(!done && !busy, {tag, " R7 single pulse then idle"}, {30'd0, done, busy}, 32'd0);
    endtask

    task automatic t_reset;
        chk(!busy && !done && !mem_rd_en && !mem_wr_en, "R1 idle after reset",
            {28'd0, busy, done, mem_rd_en, mem_wr_en}, 32'd0);
        chk(checksum == 16'hFFFF, "R1 checksum after reset", 32'(checksum), 32'hFFFF);
    endtask

    task automatic t_zero_count;
        mem[9'h180] = 8'h11; mem[9'h181] = 8'h22;
        issue(9'h040, 0, 9'h180);
        await_done("zero");
        chk({mem[9'h180], mem[9'h181]} == 16'hFFFF, "R2 empty range stores seed",
            32'({mem[9'h180], mem[9'h181]}), 32'hFFFF);
    endtask

    task automatic t_single_zero_byte;
        mem[9'h020] = 8'h00;
        issue(9'h020, 1, 9'h190);
        await_done("one");
        chk(checksum == 16'h0F87, "R5 lone zero byte", 32'(checksum), 32'h0F87);
    endtask

    task automatic t_two_zero_words;
        mem[9'h010] = 8'h00; mem[9'h011] = 8'h00; mem[9'h012] = 8'h00;
        issue(9'h010, 2, 9'h194);
        await_done("zw");
        chk(checksum == 16'hF0B8, "R4 two zero words", 32'(checksum), 32'hF0B8);
    endtask

    task automatic t_overlap;
        logic [15:0] e;
        mem[9'h030] = 8'h12; mem[9'h031] = 8'h34; mem[9'h032] = 8'h56;
        e = ref_fold(ref_fold(16'hFFFF, 16'h1234), 16'h3456);
        issue(9'h030, 2, 9'h198);
        await_done("ovl");
        chk(checksum == e, "R3 overlapping big-endian words", 32'(checksum), 32'(e));
        chk({mem[9'h198], mem[9'h199]} == e, "R6 stored overlap result",
            32'({mem[9'h198], mem[9'h199]}), 32'(e));
    endtask

    task automatic t_odd;
        logic [15:0] e;
        for (int k = 0; k < 7; k++) mem[9'h060 + k] = 8'(8'hC3 ^ (k * 29));
        e = ref_sum(9'h060, 7);
        issue(9'h060, 7, 9'h1A0);
        await_done("odd");
        chk(checksum == e, "R5 odd count tail byte", 32'(checksum), 32'(e));
    endtask

    task automatic t_header;
        logic [15:0] e;
        for (int k = 0; k < 9'h100; k++) mem[k] = 8'(k * 37 + 5);
        mem[9'h0FB] = 8'hA5; mem[9'h0FE] = 8'h5A;
        e = ref_sum(0, 9'h0F8);
        issue(0, 9'h0F8, 9'h0FC);
        await_done("hdr");
        chk(mem[9'h0FC] == e[15:8], "R6 high byte at dest", 32'(mem[9'h0FC]), 32'(e[15:8]));
        chk(mem[9'h0FD] == e[7:0], "R6 low byte at dest+1", 32'(mem[9'h0FD]), 32'(e[7:0]));
        chk(mem[9'h0FB] == 8'hA5 && mem[9'h0FE] == 8'h5A, "R6 neighbours untouched",
            32'({mem[9'h0FB], mem[9'h0FE]}), 32'hA55A);
        repeat (5) @(negedge clk);
        chk(checksum == e, "R9 checksum holds after done", 32'(checksum), 32'(e));
    endtask

    task automatic t_start_while_busy;
        logic [15:0] e;
        for (int k = 0; k < 21; k++) mem[9'h080 + k] = 8'(k * 11 + 3);
        mem[9'h1D0] = 8'h5A; mem[9'h1D1] = 8'h5A;
        e = ref_sum(9'h080, 20);
        issue(9'h080, 20, 9'h1C0);
        repeat (4) @(negedge clk);
        start = 1'b1; start_addr = '0; byte_count = AW'(3); dest_addr = 9'h1D0;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R8 still busy after second start", 32'(busy), 32'd1);
        await_done("busy");
        chk(checksum == e, "R8 first job result kept", 32'(checksum), 32'(e));
        chk({mem[9'h1C0], mem[9'h1C1]} == e, "R8 first job stored",
            32'({mem[9'h1C0], mem[9'h1C1]}), 32'(e));
        chk({mem[9'h1D0], mem[9'h1D1]} == 16'h5A5A, "R8 second dest untouched",
            32'({mem[9'h1D0], mem[9'h1D1]}), 32'h5A5A);
    endtask

    initial begin
        for (int k = 0; k < DEPTH; k++) mem[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero_count();
        t_single_zero_byte();
        t_two_zero_words();
        t_overlap();
        t_odd();
        t_header();
        t_start_while_busy();
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule